// File: doc/BRIEF.md
# Circular trace capture buffer

The block stores one 20-bit processor trace word per clock into an on-chip RAM while the capture enable input is high. The write pointer moves up by one on each stored word and wraps from the last entry back to entry 0, so the oldest entries are overwritten. A capture state machine has two states. ST_FILL means the RAM has not yet wrapped. ST_WRAPPED means the write pointer has passed the end at least once. Transition T_WRAP goes from ST_FILL to ST_WRAPPED on a capture at the last entry. Transition T_RELOAD goes from either state to ST_FILL when software writes the write pointer. There are no other transitions.

A debugger reaches the buffer through a small register port with a 3-bit select. Reads are combinational, and writes take effect at the clock edge. The register map is:

| Select | Register | Access | Contents |
|---|---|---|---|
| 0 | status | read | bit 1 is the sticky wrapped flag; all other bits read 0 |
| 1 | depth | read | the depth parameter |
| 2 | width | read | the trace word width, which is 20 |
| 3 | write pointer | read and write | the write pointer |
| 4 | read pointer | read and write | the read pointer |
| 5 | data | read | the entry at the read pointer |

Any other select reads 0. Pointers read back zero-extended.

Software reads the status register to find the oldest entry. It writes that address to the read pointer and then reads the data register repeatedly. Each data read returns one entry and steps the read pointer, wrapping modulo the depth. Clearing capture enable freezes the RAM, the write pointer and the wrapped flag, so the snapshot stays stable while it is read.

Top module: `trace_ring_buf`

## Requirements
- R1: A stored word keeps its layout unchanged: pipeline status in bits [2:0], 16-bit trace packet in bits [18:3], sync flag in bit 19. A data read returns all 20 bits exactly as captured.
- R2: After reset, status reads 0, the write pointer reads 0 and the read pointer reads 0.
- R3: While cap_en is 1 and the write pointer is not being written, trace_word is stored at the write pointer. The pointer then increments modulo DEPTH.
- R4: While cap_en is 0, the write pointer, the wrapped flag and the RAM contents do not change.
- R5: Status bit 1 becomes 1 on a capture at entry DEPTH-1. It then stays 1 (sticky) until the write pointer is written.
- R6: While status bit 1 is 0, the oldest entry is at address 0. While it is 1, the oldest entry is at the write pointer. The newest entry is always at the write pointer minus 1, modulo DEPTH.
- R7: Select 1 reads DEPTH and select 2 reads 20.
- R8: A read of select 5 returns the entry at the read pointer. The read pointer then increments modulo DEPTH.
- R9: A write to select 4 loads the read pointer. The next data read returns the entry at that address.
- R10: A write to select 3 loads the write pointer and clears status bit 1. If capture is enabled in the same cycle, the write wins and that cycle's trace word is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock for capture and register access |
| rst_n | input | 1 | active-low asynchronous reset |
| cap_en | input | 1 | capture enable |
| trace_word | input | 20 | trace word to store |
| reg_sel | input | 3 | register select |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe; advances the read pointer on select 5 |
| reg_wdata | input | PTR_W | pointer value to write |
| reg_rdata | output | 32 | register read data |

## Verification
A wrong write pointer or a wrong wrapped flag shows up on the next register read: select 3 or select 0 reports the wrong value, or read-out starts at the wrong oldest entry. The whole read-out after a wrap then comes back rotated by one or more places. A wrong read pointer shows up on the very next data read, as an entry out of sequence, most often at the wrap from DEPTH-1 to 0. A capture that is dropped or leaks through while disabled shows up only when that entry is read back. For that reason the bench reads back the whole RAM after every phase.

// File: rtl/trb_pkg.sv
package trb_pkg;
    localparam int PS_W   = 3;
    localparam int PK_W   = 16;
    localparam int WORD_W = PS_W + PK_W + 1;
    localparam int REG_W  = 32;

    localparam logic [2:0] SEL_STATUS = 3'd0;
    localparam logic [2:0] SEL_DEPTH  = 3'd1;
    localparam logic [2:0] SEL_WIDTH  = 3'd2;
    localparam logic [2:0] SEL_WPTR   = 3'd3;
    localparam logic [2:0] SEL_RPTR   = 3'd4;
    localparam logic [2:0] SEL_DATA   = 3'd5;

    typedef enum logic {
        ST_FILL    = 1'b0,
        ST_WRAPPED = 1'b1
    } cap_state_e;
endpackage

// File: rtl/trb_store.sv
module trb_store #(
    parameter int DEPTH = 2048,
    parameter int WIDTH = 20,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/trb_capture.sv
module trb_capture
    import trb_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          wptr_load,
    input  logic [PW-1:0] wptr_val,
    output logic          mem_we,
    output logic [PW-1:0] wptr,
    output logic          wrapped
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    cap_state_e    state_q, state_d;
    logic [PW-1:0] wptr_q, wptr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            wptr_q  <= '0;
        end else begin
            state_q <= state_d;
            wptr_q  <= wptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (!wptr_load && cap_en && wptr_q == LAST) begin
                    state_d = ST_WRAPPED;
                end
            end
            ST_WRAPPED: begin
                if (wptr_load) begin
                    state_d = ST_FILL;
                end
            end
            default: state_d = ST_FILL;
        endcase
    end

    always_comb begin
        mem_we = cap_en && !wptr_load;
        if (wptr_load) begin
            wptr_d = wptr_val;
        end else if (cap_en) begin
            wptr_d = wptr_q + 1'b1;
        end else begin
            wptr_d = wptr_q;
        end
    end

    assign wptr    = wptr_q;
    assign wrapped = (state_q == ST_WRAPPED);
endmodule

// File: rtl/trb_regs.sv
module trb_regs
    import trb_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [PW-1:0]     reg_wdata,
    input  logic              wrapped,
    input  logic [PW-1:0]     wptr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              wptr_load,
    output logic [PW-1:0]     rptr,
    output logic [REG_W-1:0]  reg_rdata
);
    logic [PW-1:0] rptr_q;
    logic          rptr_load, data_pop;

    assign wptr_load = reg_wr && (reg_sel == SEL_WPTR);
    assign rptr_load = reg_wr && (reg_sel == SEL_RPTR);
    assign data_pop  = reg_rd && (reg_sel == SEL_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr_q <= '0;
        end else if (rptr_load) begin
            rptr_q <= reg_wdata;
        end else if (data_pop) begin
            rptr_q <= rptr_q + 1'b1;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_STATUS: reg_rdata = {{(REG_W-2){1'b0}}, wrapped, 1'b0};
            SEL_DEPTH:  reg_rdata = REG_W'(DEPTH);
            SEL_WIDTH:  reg_rdata = REG_W'(WORD_W);
            SEL_WPTR:   reg_rdata = {{(REG_W-PW){1'b0}}, wptr};
            SEL_RPTR:   reg_rdata = {{(REG_W-PW){1'b0}}, rptr_q};
            SEL_DATA:   reg_rdata = {{(REG_W-WORD_W){1'b0}}, mem_rdata};
            default:    reg_rdata = '0;
        endcase
    end

    assign rptr = rptr_q;
endmodule

// File: rtl/trace_ring_buf.sv
module trace_ring_buf
    import trb_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [WORD_W-1:0] trace_word,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [PTR_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    logic              mem_we, wptr_load, wrapped;
    logic [PTR_W-1:0]  wptr, rptr;
    logic [WORD_W-1:0] mem_rdata;

    trb_capture #(.DEPTH(DEPTH)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
        .wptr_load(wptr_load), .wptr_val(reg_wdata),
        .mem_we(mem_we), .wptr(wptr), .wrapped(wrapped)
    );

    trb_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_store (
        .clk(clk), .we(mem_we), .waddr(wptr), .wdata(trace_word),
        .raddr(rptr), .rdata(mem_rdata)
    );

    trb_regs #(.DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .wrapped(wrapped),
        .wptr(wptr), .mem_rdata(mem_rdata), .wptr_load(wptr_load),
        .rptr(rptr), .reg_rdata(reg_rdata)
    );
endmodule

// File: rtl/trb_checker.sv
module trb_checker #(
    parameter int DEPTH = 2048,
    localparam int PW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cap_en,
    input logic [2:0]    reg_sel,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [PW-1:0] reg_wdata,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr,
    input logic          wrapped
);
    logic wload, rload, pop;
    assign wload = reg_wr && reg_sel == 3'd3;
    assign rload = reg_wr && reg_sel == 3'd4;
    assign pop   = reg_rd && reg_sel == 3'd5;

    a_r2_reset_ptrs: assert property (@(posedge clk) $rose(rst_n) |-> (wptr == '0 && rptr == '0 && !wrapped));

    a_r3_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !wload) |=> wptr == $past(wptr) + 1'b1);

    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !wload) |=> ($stable(wptr) && $stable(wrapped)));

    a_r5_wrap_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !wload && wptr == PW'(DEPTH - 1)) |=> wrapped);

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wrapped && !wload) |=> wrapped);

    a_r8_rptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !rload) |=> rptr == $past(rptr) + 1'b1);

    a_r9_rptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        rload |=> rptr == $past(reg_wdata));

    a_r10_wptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        wload |=> (wptr == $past(reg_wdata) && !wrapped));
endmodule

bind trace_ring_buf trb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .wptr(wptr), .rptr(rptr), .wrapped(wrapped)
);

// File: tb/trace_ring_buf_tb_top.sv
module trace_ring_buf_tb_top;
    localparam int D  = 16;
    localparam int PW = 4;

    logic        clk = 0, rst_n = 0, cap_en = 0, reg_wr = 0, reg_rd = 0;
    logic [19:0] trace_word = '0;
    logic [2:0]  reg_sel = '0;
    logic [PW-1:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int total = 0, bad = 0;
    logic [19:0] exp_mem [D];
    int exp_wptr = 0;
    bit exp_wrap = 0;

    always #5 clk = ~clk;

    trace_ring_buf #(.DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .trace_word(trace_word),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [2:0] sel, output logic [31:0] val);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1;
        #1 val = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 0;
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [PW-1:0] v, input bit with_cap);
        @(negedge clk);
        reg_sel = sel; reg_wdata = v; reg_wr = 1;
        cap_en = with_cap; trace_word = 20'hABCDE;
        @(posedge clk);
        #1 reg_wr = 0; cap_en = 0;
        if (sel == 3'd3) begin
            exp_wptr = v; exp_wrap = 0;
        end
    endtask

    task automatic capture(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cap_en = 1;
            trace_word = 20'((seed + i) * 20'h1357B + 20'h0F0F1);
            exp_mem[exp_wptr] = trace_word;
            if (exp_wptr == D - 1) exp_wrap = 1;
            exp_wptr = (exp_wptr + 1) % D;
        end
        @(posedge clk);
        #1 cap_en = 0;
    endtask

    task automatic dump_from(input int start, input int n, input string req);
        logic [31:0] v;
        wr_reg(3'd4, PW'(start), 0);
        for (int i = 0; i < n; i++) begin
            rd_reg(3'd5, v);
            check(req, v, {12'd0, exp_mem[(start + i) % D]});
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd_reg(3'd0, v); check("R2 status", v, 0);
        rd_reg(3'd3, v); check("R2 wptr", v, 0);
        rd_reg(3'd4, v); check("R2 rptr", v, 0);
        rd_reg(3'd1, v); check("R7 depth", v, D);
        rd_reg(3'd2, v); check("R7 width", v, 20);
    endtask

    task automatic t_fill;
        logic [31:0] v;
        capture(5, 1);
        rd_reg(3'd3, v); check("R3 wptr after 5", v, 5);
        rd_reg(3'd0, v); check("R6 no wrap yet", v, 0);
        dump_from(0, 5, "R3 R6 oldest at 0");
        dump_from(exp_wptr - 1, 1, "R6 newest at wptr-1");
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        capture(14, 40);
        rd_reg(3'd0, v); check("R5 wrapped", v, 2);
        rd_reg(3'd3, v); check("R3 wptr modulo", v, 3);
        dump_from(exp_wptr, D, "R6 R8 oldest at wptr");
        rd_reg(3'd4, v); check("R8 rptr modulo after full read", v, 3);
        capture(2, 90);
        rd_reg(3'd0, v); check("R5 sticky", v, 2);
    endtask

    task automatic t_freeze;
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cap_en = 0; trace_word = 20'(i * 20'h11111);
        end
        rd_reg(3'd3, v); check("R4 wptr frozen", v, exp_wptr);
        rd_reg(3'd0, v); check("R4 flag frozen", v, 2);
        dump_from(0, D, "R4 contents frozen");
    endtask

    task automatic t_rptr;
        logic [31:0] v;
        wr_reg(3'd4, PW'(D - 1), 0);
        rd_reg(3'd5, v); check("R9 read at loaded rptr", v, {12'd0, exp_mem[D-1]});
        rd_reg(3'd5, v); check("R8 rptr wraps to 0", v, {12'd0, exp_mem[0]});
        rd_reg(3'd4, v); check("R8 rptr value", v, 1);
    endtask

    task automatic t_wload;
        logic [31:0] v;
        int old;
        old = exp_wptr;
        wr_reg(3'd3, 4'd9, 1);
        rd_reg(3'd0, v); check("R10 flag cleared", v, 0);
        rd_reg(3'd3, v); check("R10 wptr loaded", v, 9);
        dump_from(old, 1, "R10 capture dropped");
        capture(2, 200);
        rd_reg(3'd3, v); check("R10 R3 capture from loaded", v, 11);
        dump_from(0, D, "R10 contents");
    endtask

    task automatic t_layout;
        logic [31:0] v;
        logic [2:0] ps; logic [15:0] pk; logic sy;
        ps = 3'b101; pk = 16'hC3A5; sy = 1'b1;
        @(negedge clk);
        cap_en = 1; trace_word = {sy, pk, ps};
        exp_mem[exp_wptr] = trace_word;
        @(posedge clk);
        #1 cap_en = 0;
        wr_reg(3'd4, PW'(exp_wptr), 0);
        exp_wptr = (exp_wptr + 1) % D;
        rd_reg(3'd5, v);
        check("R1 pipe status", v[2:0], ps);
        check("R1 packet", v[18:3], pk);
        check("R1 sync", v[19], sy);
        check("R1 upper zero", v[31:20], 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset;
        t_fill;
        t_wrap;
        t_freeze;
        t_rptr;
        t_wload;
        t_layout;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule